// File: doc/BRIEF.md
# Calendar Clock Update Engine

This block holds the time of day and the calendar date (seconds, minutes, hours, weekday, day of month, month, two-digit year) and moves them forward once per second. A host reaches every byte through a small synchronous register bus: an index, a write strobe with a data byte, and a combinational read-data return. The presentation of each byte follows two runtime switches in the control byte. One picks BCD or plain binary. The other picks a 24-hour clock or a 12-hour clock with a PM flag.

Each second begins with a one-cycle second tick. The block then opens an update window that is timed in reference-clock enables. The update-in-progress flag goes high at once. The counters change a fixed number of reference ticks later, and the flag stays high until the window closes. At the close, a one-cycle done pulse is sent to neighbouring interrupt logic. While software is loading a new time, a hold bit in the control byte keeps any window from starting and cancels one that is already open.

Top module: `cal_clock_engine`

## Requirements
- R1: After reset the reads are: index 0 = 0x00, 2 = 0x00, 4 = 0x00, 6 = 0x01, 7 = 0x01, 8 = 0x01, 9 = 0x00, 10 = 0x00, 11 = 0x02. Both uip_o and upd_done_o are low.
- R2: The time fields sit at these indices: seconds 0, minutes 2, hours 4, weekday 6, day of month 7, month 8, year 9. Indices 1, 3, 5 and 12 always read 0x00, and writes to them change nothing.
- R3: Control index 11, bit 2 (0x04), sets the encoding. When clear, every time byte is read and written as BCD. When set, every time byte is plain binary. Changing the bit re-presents the stored time and does not alter it.
- R4: Control bit 1 (0x02), when set, gives hours 0–23. When clear, hours run 1–12 in bits 6:0, and bit 7 = 1 means PM. Midnight reads 12 AM and noon reads 12 PM.
- R5: Each update adds one second. Seconds wrap 59→0 and carry into minutes. Minutes wrap 59→0 and carry into hours. Hours wrap at 23→0 (24-hour view).
- R6: When the hour wraps, the day of month advances and wraps to 1 after the month's last day. Months 4, 6, 9 and 11 have 30 days. February has 29 days when year mod 4 = 0 and 28 otherwise. All other months have 31 days. Month wraps 12→1 and then carries into the year, which wraps 99→0.
- R7: Weekday counts 1–7. It advances when the hour wraps, going from 7 back to 1.
- R8: uip_o and bit 7 of index 10 rise in the cycle after a second tick. The counters change LEAD_TICKS (8) reference ticks later. The flag stays high for WINDOW_TICKS (73) reference ticks in total. A second tick that arrives during a window is ignored.
- R9: upd_done_o is high for exactly one cycle, in the first cycle where uip_o is low again after a completed window.
- R10: While control bit 7 (0x80) is set, no window starts. An open window is closed one cycle after the bit is registered, with no advance and no done pulse.
- R11: A host write to a time field is seen on the next cycle and never carries into a neighbouring field. If the write lands in the advance cycle, the written field takes the host value. The other fields advance using the values from before the write.
- R12: Index 13 always reads 0x80. Bits 6:0 of index 10 read 0, and writes to index 10 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Reference-clock enable that paces the update window |
| sec_tick | input | 1 | One-cycle pulse once per second that requests an update |
| bus_addr | input | 4 | Register index |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| uip_o | output | 1 | Update in progress |
| upd_done_o | output | 1 | One-cycle pulse when an update window completes |

## Verification
The two functions that can fall in the same cycle are a host write to a time field and the once-per-second advance of the counter chain. The bench counts clock edges from the second tick so that a seconds write is held on the bus exactly on the advance edge, with seconds at 59. The result is judged correct when seconds hold the host value and minutes have still taken the carry from the old 59. The other bench scenarios cover the window's cycle-exact shape, an abort by the hold bit, and calendar wraps in both encodings and both hour formats.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 4;

    typedef logic [BYTE_W-1:0] byte_t;

    localparam logic [ADDR_W-1:0] IDX_SEC   = 4'd0;
    localparam logic [ADDR_W-1:0] IDX_MIN   = 4'd2;
    localparam logic [ADDR_W-1:0] IDX_HOUR  = 4'd4;
    localparam logic [ADDR_W-1:0] IDX_WDAY  = 4'd6;
    localparam logic [ADDR_W-1:0] IDX_MDAY  = 4'd7;
    localparam logic [ADDR_W-1:0] IDX_MON   = 4'd8;
    localparam logic [ADDR_W-1:0] IDX_YEAR  = 4'd9;
    localparam logic [ADDR_W-1:0] IDX_STAT  = 4'd10;
    localparam logic [ADDR_W-1:0] IDX_CTRL  = 4'd11;
    localparam logic [ADDR_W-1:0] IDX_VALID = 4'd13;

    localparam int CTL_HOLD = 7;
    localparam int CTL_BIN  = 2;
    localparam int CTL_H24  = 1;
    localparam byte_t CTRL_RST  = 8'h02;
    localparam byte_t VALID_VAL = 8'h80;

    typedef enum logic [2:0] {
        FLD_SEC, FLD_MIN, FLD_HOUR, FLD_WDAY, FLD_MDAY, FLD_MON, FLD_YEAR, FLD_NONE
    } field_e;

    typedef enum logic [1:0] {WIN_IDLE, WIN_LEAD, WIN_TAIL} win_e;

    typedef struct packed {
        byte_t sec;
        byte_t min;
        byte_t hour;
        byte_t wday;
        byte_t mday;
        byte_t mon;
        byte_t year;
    } caltime_t;

    typedef struct packed {
        logic hold;
        logic binary;
        logic h24;
    } mode_t;

    function automatic byte_t to_bcd(input byte_t v);
        byte_t tens;
        byte_t ones;
        tens = v / 8'd10;
        ones = v - tens * 8'd10;
        return {tens[3:0], ones[3:0]};
    endfunction

    function automatic byte_t from_bcd(input byte_t b);
        return {4'd0, b[7:4]} * 8'd10 + {4'd0, b[3:0]};
    endfunction

    function automatic byte_t enc_val(input byte_t v, input logic binary);
        return binary ? v : to_bcd(v);
    endfunction

    function automatic byte_t dec_val(input byte_t b, input logic binary);
        return binary ? b : from_bcd(b);
    endfunction

    function automatic byte_t enc_hour(input byte_t hr, input logic binary, input logic h24);
        byte_t h12;
        logic  pm;
        if (h24) return enc_val(hr, binary);
        pm  = (hr >= 8'd12);
        h12 = pm ? hr - 8'd12 : hr;
        if (h12 == 8'd0) h12 = 8'd12;
        h12 = enc_val(h12, binary);
        return {pm, h12[6:0]};
    endfunction

    function automatic byte_t dec_hour(input byte_t b, input logic binary, input logic h24);
        byte_t h12;
        if (h24) return dec_val(b, binary);
        h12 = dec_val({1'b0, b[6:0]}, binary);
        if (h12 == 8'd12) h12 = 8'd0;
        return b[7] ? h12 + 8'd12 : h12;
    endfunction

    function automatic byte_t month_len(input byte_t mon, input byte_t year);
        case (mon)
            8'd2:                         return (year % 8'd4 == 8'd0) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:      return 8'd30;
            default:                      return 8'd31;
        endcase
    endfunction

endpackage

// File: rtl/cal_update_window.sv
module cal_update_window
    import cal_pkg::*;
#(
    parameter int LEAD_TICKS   = 8,
    parameter int WINDOW_TICKS = 73
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_tick,
    input  logic sec_tick,
    input  logic hold,
    output logic uip,
    output logic advance,
    output logic done
);
    localparam int TAIL_TICKS = WINDOW_TICKS - LEAD_TICKS;
    localparam int CNT_W      = $clog2(WINDOW_TICKS + 1);
    localparam logic [CNT_W-1:0] LEAD_LAST = CNT_W'(LEAD_TICKS - 1);
    localparam logic [CNT_W-1:0] TAIL_LAST = CNT_W'(TAIL_TICKS - 1);

    win_e             state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;
    logic             lead_end;
    logic             tail_end;

    assign lead_end = (state_q == WIN_LEAD) && ref_tick && (cnt_q == LEAD_LAST);
    assign tail_end = (state_q == WIN_TAIL) && ref_tick && (cnt_q == TAIL_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WIN_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (hold) begin
                state_q <= WIN_IDLE;
                cnt_q   <= '0;
            end else begin
                case (state_q)
                    WIN_IDLE: if (sec_tick) begin
                        state_q <= WIN_LEAD;
                        cnt_q   <= '0;
                    end
                    WIN_LEAD: if (ref_tick) begin
                        if (lead_end) begin
                            state_q <= WIN_TAIL;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    WIN_TAIL: if (ref_tick) begin
                        if (tail_end) begin
                            state_q <= WIN_IDLE;
                            cnt_q   <= '0;
                            done_q  <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: state_q <= WIN_IDLE;
                endcase
            end
        end
    end

    assign uip     = (state_q != WIN_IDLE);
    assign advance = lead_end && !hold;
    assign done    = done_q;

    // R9
    done_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_after_window_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!uip && $past(uip)));

    // R8
    window_after_adv_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && !hold) |=> uip);

    // R10
    hold_closes_chk: assert property (@(posedge clk) disable iff (rst)
        hold |=> (!uip && !done));

endmodule

// File: rtl/cal_counter_chain.sv
module cal_counter_chain
    import cal_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     advance,
    input  logic     wr_en,
    input  field_e   wr_sel,
    input  byte_t    wr_val,
    output caltime_t now
);
    caltime_t cur_q;
    caltime_t nxt;
    logic s_wrap, m_wrap, h_wrap, d_wrap, mo_wrap;

    always_comb begin
        s_wrap  = (cur_q.sec >= 8'd59);
        m_wrap  = s_wrap && (cur_q.min >= 8'd59);
        h_wrap  = m_wrap && (cur_q.hour >= 8'd23);
        d_wrap  = h_wrap && (cur_q.mday >= month_len(cur_q.mon, cur_q.year));
        mo_wrap = d_wrap && (cur_q.mon >= 8'd12);

        nxt = cur_q;
        if (advance) begin
            nxt.sec = s_wrap ? 8'd0 : cur_q.sec + 8'd1;
            if (s_wrap)  nxt.min  = m_wrap ? 8'd0 : cur_q.min + 8'd1;
            if (m_wrap)  nxt.hour = h_wrap ? 8'd0 : cur_q.hour + 8'd1;
            if (h_wrap) begin
                nxt.wday = (cur_q.wday >= 8'd7) ? 8'd1 : cur_q.wday + 8'd1;
                nxt.mday = d_wrap ? 8'd1 : cur_q.mday + 8'd1;
            end
            if (d_wrap)  nxt.mon  = mo_wrap ? 8'd1 : cur_q.mon + 8'd1;
            if (mo_wrap) nxt.year = (cur_q.year >= 8'd99) ? 8'd0 : cur_q.year + 8'd1;
        end

        if (wr_en) begin
            case (wr_sel)
                FLD_SEC:  nxt.sec  = wr_val;
                FLD_MIN:  nxt.min  = wr_val;
                FLD_HOUR: nxt.hour = wr_val;
                FLD_WDAY: nxt.wday = wr_val;
                FLD_MDAY: nxt.mday = wr_val;
                FLD_MON:  nxt.mon  = wr_val;
                FLD_YEAR: nxt.year = wr_val;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '{sec: 8'd0, min: 8'd0, hour: 8'd0, wday: 8'd1,
                       mday: 8'd1, mon: 8'd1, year: 8'd0};
        end else begin
            cur_q <= nxt;
        end
    end

    assign now = cur_q;

    // R5
    sec_range_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && !(wr_en && wr_sel == FLD_SEC)) |=> (cur_q.sec < 8'd60));

    // R7
    wday_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && h_wrap && !(wr_en && wr_sel == FLD_WDAY)) |=>
        (cur_q.wday >= 8'd1 && cur_q.wday <= 8'd7));

    // R11
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!advance && !wr_en) |=> $stable(cur_q));

endmodule

// File: rtl/cal_host_regs.sv
module cal_host_regs
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  byte_t             wdata,
    input  logic              uip,
    input  caltime_t          now,
    output byte_t             rdata,
    output mode_t             mode,
    output logic              fld_wr,
    output field_e            fld_sel,
    output byte_t             fld_val
);
    byte_t ctrl_q;

    assign mode.hold   = ctrl_q[CTL_HOLD];
    assign mode.binary = ctrl_q[CTL_BIN];
    assign mode.h24    = ctrl_q[CTL_H24];

    always_ff @(posedge clk) begin
        if (rst)                          ctrl_q <= CTRL_RST;
        else if (wr && addr == IDX_CTRL)  ctrl_q <= wdata;
    end

    always_comb begin
        fld_sel = FLD_NONE;
        fld_val = dec_val(wdata, mode.binary);
        case (addr)
            IDX_SEC:  fld_sel = FLD_SEC;
            IDX_MIN:  fld_sel = FLD_MIN;
            IDX_HOUR: begin
                fld_sel = FLD_HOUR;
                fld_val = dec_hour(wdata, mode.binary, mode.h24);
            end
            IDX_WDAY: fld_sel = FLD_WDAY;
            IDX_MDAY: fld_sel = FLD_MDAY;
            IDX_MON:  fld_sel = FLD_MON;
            IDX_YEAR: fld_sel = FLD_YEAR;
            default:  fld_sel = FLD_NONE;
        endcase
        fld_wr = wr && (fld_sel != FLD_NONE);
    end

    always_comb begin
        case (addr)
            IDX_SEC:   rdata = enc_val(now.sec, mode.binary);
            IDX_MIN:   rdata = enc_val(now.min, mode.binary);
            IDX_HOUR:  rdata = enc_hour(now.hour, mode.binary, mode.h24);
            IDX_WDAY:  rdata = enc_val(now.wday, mode.binary);
            IDX_MDAY:  rdata = enc_val(now.mday, mode.binary);
            IDX_MON:   rdata = enc_val(now.mon, mode.binary);
            IDX_YEAR:  rdata = enc_val(now.year, mode.binary);
            IDX_STAT:  rdata = {uip, 7'd0};
            IDX_CTRL:  rdata = ctrl_q;
            IDX_VALID: rdata = VALID_VAL;
            default:   rdata = 8'd0;
        endcase
    end

    // R10
    ctrl_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == IDX_CTRL) |=> (mode.hold == $past(wdata[CTL_HOLD])));

endmodule

// File: rtl/cal_clock_engine.sv
module cal_clock_engine
    import cal_pkg::*;
#(
    parameter int LEAD_TICKS   = 8,
    parameter int WINDOW_TICKS = 73
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_tick,
    input  logic              sec_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              uip_o,
    output logic              upd_done_o
);
    mode_t    mode;
    caltime_t now;
    logic     advance;
    logic     fld_wr;
    field_e   fld_sel;
    byte_t    fld_val;

    cal_update_window #(
        .LEAD_TICKS  (LEAD_TICKS),
        .WINDOW_TICKS(WINDOW_TICKS)
    ) u_window (
        .clk     (clk),
        .rst     (rst),
        .ref_tick(ref_tick),
        .sec_tick(sec_tick),
        .hold    (mode.hold),
        .uip     (uip_o),
        .advance (advance),
        .done    (upd_done_o)
    );

    cal_counter_chain u_chain (
        .clk    (clk),
        .rst    (rst),
        .advance(advance),
        .wr_en  (fld_wr),
        .wr_sel (fld_sel),
        .wr_val (fld_val),
        .now    (now)
    );

    cal_host_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .addr   (bus_addr),
        .wr     (bus_wr),
        .wdata  (bus_wdata),
        .uip    (uip_o),
        .now    (now),
        .rdata  (bus_rdata),
        .mode   (mode),
        .fld_wr (fld_wr),
        .fld_sel(fld_sel),
        .fld_val(fld_val)
    );

endmodule

// File: tb/cal_clock_engine_tb.sv
module cal_clock_engine_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_tick = 1'b1;
    logic       sec_tick = 1'b0;
    logic [3:0] bus_addr = 4'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       uip_o;
    logic       upd_done_o;

    int total = 0;
    int bad = 0;

    cal_clock_engine u_dut (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .sec_tick(sec_tick),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .uip_o(uip_o), .upd_done_o(upd_done_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rchk(input string req, input logic [3:0] a, input logic [7:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1 chk(req, bus_rdata, exp);
    endtask

    task automatic set_time(input logic [7:0] mode, input logic [7:0] yr, input logic [7:0] mo,
                            input logic [7:0] md, input logic [7:0] wd, input logic [7:0] hr,
                            input logic [7:0] mi, input logic [7:0] se);
        wr(4'd11, mode | 8'h80);
        wr(4'd9, yr); wr(4'd8, mo); wr(4'd7, md); wr(4'd6, wd);
        wr(4'd4, hr); wr(4'd2, mi); wr(4'd0, se);
        wr(4'd11, mode);
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic wait_done();
        for (int n = 0; n < 300; n++) begin
            @(negedge clk);
            if (upd_done_o) return;
        end
        chk("R9 done never seen", 8'd0, 8'd1);
    endtask

    task automatic run_update();
        pulse_tick();
        wait_done();
    endtask

    task automatic t_reset();
        chk("R1 uip", {7'd0, uip_o}, 8'd0);
        chk("R1 done", {7'd0, upd_done_o}, 8'd0);
        rchk("R1 sec", 4'd0, 8'h00); rchk("R1 min", 4'd2, 8'h00);
        rchk("R1 hour", 4'd4, 8'h00); rchk("R1 wday", 4'd6, 8'h01);
        rchk("R1 mday", 4'd7, 8'h01); rchk("R1 mon", 4'd8, 8'h01);
        rchk("R1 year", 4'd9, 8'h00); rchk("R1 stat", 4'd10, 8'h00);
        rchk("R1 ctrl", 4'd11, 8'h02); rchk("R12 valid", 4'd13, 8'h80);
    endtask

    task automatic t_index();
        set_time(8'h06, 8'd9, 8'd8, 8'd7, 8'd6, 8'd4, 8'd2, 8'd17);
        rchk("R2 sec", 4'd0, 8'd17); rchk("R2 min", 4'd2, 8'd2);
        rchk("R2 hour", 4'd4, 8'd4); rchk("R2 wday", 4'd6, 8'd6);
        rchk("R2 mday", 4'd7, 8'd7); rchk("R2 mon", 4'd8, 8'd8);
        rchk("R2 year", 4'd9, 8'd9);
        wr(4'd1, 8'h55); wr(4'd3, 8'h55); wr(4'd5, 8'h55); wr(4'd12, 8'h55);
        wr(4'd10, 8'h7F);
        rchk("R2 idx1", 4'd1, 8'h00); rchk("R2 idx3", 4'd3, 8'h00);
        rchk("R2 idx5", 4'd5, 8'h00); rchk("R2 idx12", 4'd12, 8'h00);
        rchk("R12 stat", 4'd10, 8'h00); rchk("R12 valid", 4'd13, 8'h80);
        rchk("R2 sec kept", 4'd0, 8'd17); rchk("R2 hour kept", 4'd4, 8'd4);
    endtask

    task automatic t_bcd();
        set_time(8'h02, 8'h23, 8'h06, 8'h15, 8'h03, 8'h09, 8'h09, 8'h59);
        run_update();
        rchk("R3 bcd sec", 4'd0, 8'h00); rchk("R3 bcd min", 4'd2, 8'h10);
        rchk("R5 hour", 4'd4, 8'h09);
        wr(4'd11, 8'h06);
        rchk("R3 bin min", 4'd2, 8'h0A); rchk("R3 bin year", 4'd9, 8'h17);
        rchk("R3 bin mday", 4'd7, 8'h0F);
    endtask

    task automatic t_rollover();
        set_time(8'h06, 8'd99, 8'd12, 8'd31, 8'd7, 8'd23, 8'd59, 8'd59);
        run_update();
        rchk("R5 sec", 4'd0, 8'd0); rchk("R5 min", 4'd2, 8'd0);
        rchk("R5 hour", 4'd4, 8'd0); rchk("R7 wday", 4'd6, 8'd1);
        rchk("R6 mday", 4'd7, 8'd1); rchk("R6 mon", 4'd8, 8'd1);
        rchk("R6 year", 4'd9, 8'd0);
    endtask

    task automatic t_months();
        set_time(8'h06, 8'd4, 8'd2, 8'd28, 8'd3, 8'd23, 8'd59, 8'd59);
        run_update();
        rchk("R6 leap feb29 mday", 4'd7, 8'd29); rchk("R6 leap feb29 mon", 4'd8, 8'd2);
        rchk("R7 wday step", 4'd6, 8'd4);
        set_time(8'h06, 8'd4, 8'd2, 8'd29, 8'd3, 8'd23, 8'd59, 8'd59);
        run_update();
        rchk("R6 leap end mday", 4'd7, 8'd1); rchk("R6 leap end mon", 4'd8, 8'd3);
        set_time(8'h06, 8'd5, 8'd2, 8'd28, 8'd3, 8'd23, 8'd59, 8'd59);
        run_update();
        rchk("R6 feb28 mday", 4'd7, 8'd1); rchk("R6 feb28 mon", 4'd8, 8'd3);
        set_time(8'h06, 8'd5, 8'd4, 8'd30, 8'd3, 8'd23, 8'd59, 8'd59);
        run_update();
        rchk("R6 apr30 mday", 4'd7, 8'd1); rchk("R6 apr30 mon", 4'd8, 8'd5);
        set_time(8'h06, 8'd5, 8'd1, 8'd30, 8'd3, 8'd23, 8'd59, 8'd59);
        run_update();
        rchk("R6 jan30 mday", 4'd7, 8'd31); rchk("R6 jan30 mon", 4'd8, 8'd1);
    endtask

    task automatic t_12h();
        set_time(8'h00, 8'h10, 8'h05, 8'h10, 8'h02, 8'h91, 8'h59, 8'h59);
        run_update();
        rchk("R4 midnight 12h", 4'd4, 8'h12);
        wr(4'd11, 8'h02);
        rchk("R4 midnight 24h", 4'd4, 8'h00);
        set_time(8'h00, 8'h10, 8'h05, 8'h10, 8'h02, 8'h11, 8'h59, 8'h59);
        run_update();
        rchk("R4 noon 12h", 4'd4, 8'h92);
        set_time(8'h04, 8'd10, 8'd5, 8'd10, 8'd2, 8'h8B, 8'd0, 8'd0);
        rchk("R4 bin pm 12h", 4'd4, 8'h8B);
        wr(4'd11, 8'h06);
        rchk("R4 bin pm 24h", 4'd4, 8'd23);
    endtask

    task automatic t_window();
        set_time(8'h06, 8'd1, 8'd1, 8'd1, 8'd1, 8'd0, 8'd0, 8'd5);
        @(negedge clk);
        bus_addr = 4'd0;
        chk("R8 uip before tick", {7'd0, uip_o}, 8'd0);
        sec_tick = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sec_tick = 1'b0;
        for (int i = 0; i < 73; i++) begin
            chk("R8 uip in window", {7'd0, uip_o}, 8'd1);
            if (i == 7) chk("R8 sec before advance", bus_rdata, 8'd5);
            if (i == 8) chk("R8 sec after advance", bus_rdata, 8'd6);
            if (i == 20) begin
                bus_addr = 4'd10;
                #1 chk("R8 status bit", bus_rdata, 8'h80);
                bus_addr = 4'd0;
            end
            if (i == 30) begin
                sec_tick = 1'b1;
                chk("R9 no early done", {7'd0, upd_done_o}, 8'd0);
            end
            @(posedge clk);
            @(negedge clk);
            sec_tick = 1'b0;
        end
        chk("R8 uip falls", {7'd0, uip_o}, 8'd0);
        chk("R9 done pulse", {7'd0, upd_done_o}, 8'd1);
        @(posedge clk);
        @(negedge clk);
        chk("R9 done one cycle", {7'd0, upd_done_o}, 8'd0);
        chk("R8 extra tick ignored", {7'd0, uip_o}, 8'd0);
        rchk("R8 single advance", 4'd0, 8'd6);
    endtask

    task automatic t_hold();
        int seen_uip;
        int seen_done;
        set_time(8'h06, 8'd1, 8'd1, 8'd1, 8'd1, 8'd0, 8'd0, 8'd10);
        wr(4'd11, 8'h86);
        pulse_tick();
        seen_uip = 0;
        for (int n = 0; n < 100; n++) begin
            @(negedge clk);
            if (uip_o) seen_uip++;
        end
        chk("R10 no window while held", 8'(seen_uip), 8'd0);
        rchk("R10 time held", 4'd0, 8'd10);
        wr(4'd11, 8'h06);
        pulse_tick();
        chk("R10 window opened", {7'd0, uip_o}, 8'd1);
        wr(4'd11, 8'h86);
        seen_uip = 0;
        seen_done = 0;
        for (int n = 0; n < 100; n++) begin
            @(negedge clk);
            if (uip_o) seen_uip++;
            if (upd_done_o) seen_done++;
        end
        chk("R10 abort uip", 8'(seen_uip), 8'd0);
        chk("R10 abort no done", 8'(seen_done), 8'd0);
        rchk("R10 abort no advance", 4'd0, 8'd10);
        wr(4'd11, 8'h06);
    endtask

    task automatic t_collide();
        set_time(8'h06, 8'd1, 8'd1, 8'd1, 8'd1, 8'd3, 8'd5, 8'd40);
        wr(4'd0, 8'd59);
        rchk("R11 write seen", 4'd0, 8'd59);
        rchk("R11 no carry", 4'd2, 8'd5);
        pulse_tick();
        for (int i = 0; i < 7; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
        bus_addr = 4'd0; bus_wdata = 8'd30; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        wait_done();
        rchk("R11 write wins", 4'd0, 8'd30);
        rchk("R11 carry from old sec", 4'd2, 8'd6);
        rchk("R11 hour untouched", 4'd4, 8'd3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R8: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_index();
        t_bcd();
        t_rollover();
        t_months();
        t_12h();
        t_window();
        t_hold();
        t_collide();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule